// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave placed in front of a 2,048-byte memory array. The SCL and SDA lines reach it already synchronized to the system clock. The block detects start and stop conditions from those lines. It then decodes an address byte that holds a fixed 4-bit type code, a 3-bit block number and a direction bit. For writes it takes a word address and a run of data bytes. For reads it streams bytes back, one after another. The block only pulls the data line low, through an open-drain enable. The bench or the pad ring forms the wired-AND line from that enable.

Written bytes first go into a small page buffer. They reach the array only when the master ends the transfer with a stop condition. The array is then updated during an internal write cycle of a fixed number of system clocks. While that cycle runs, `busy` is high and the block ignores the bus. A write-protect input can cancel a pending write before it commits. It can also ruin a write that is already in progress, in which case the affected bytes read back as a poison value.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset, `sda_oe` and `busy` are low and every array location reads 8'hFF.
- R2: Before a start condition, clocked bytes are ignored and are never acknowledged.
- R3: The address byte is laid out as bits [7:4] type code 4'b1010, bits [3:1] block number (address bits 10:8) and bit 0 direction (1 = read). A byte with the right type code is acknowledged by driving SDA low in the ninth clock. Any other type code is not acknowledged, and the block then waits for a new start.
- R4: A write transfer consists of an address byte with bit 0 = 0, a word address byte (address bits 7:0) and data bytes. Each of these bytes is acknowledged. When the transfer ends with a stop, byte i lands at address (block*256 + word + i) mod 2048.
- R5: If a write transfer ends with a repeated start instead of a stop, its data is discarded and no write cycle begins.
- R6: WP is checked from the rising SCL edge that captures the last bit of the first data byte until the stop. If WP is high at any point in that window, the write is cancelled, `busy` stays low and the array is unchanged.
- R7: If WP goes high while the internal write cycle runs, every byte of that transfer reads back as POISON (default 8'hE5).
- R8: `busy` is high for exactly TWR_CYCLES system clocks after a committing stop. During that time the block does not acknowledge its address and never drives SDA.
- R9: In a read, each master acknowledge (SDA low in the ninth clock) makes the block send the next sequential byte. A master not-acknowledge releases the line, and later bytes without a new start are ignored.
- R10: The address pointer wraps from 0x7FF to 0x000, for both sequential reads and multi-byte writes.
- R11: SDA is sampled on rising SCL edges. The block changes `sda_oe` only after a falling SCL edge and never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized serial clock line |
| sda_in | input | 1 | Synchronized serial data line (wired-AND value) |
| wp | input | 1 | Write protect, active high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the block with PAGE_BYTES = 4 and TWR_CYCLES = 400. With those values, a complete address attempt fits inside one write cycle, so the bench can check the NACK while busy. It can also raise WP partway through a write cycle and count the exact busy length. A 4-byte page keeps the random write bursts within the buffer. The bench drives random bursts of one to four bytes to random addresses, including writes that cross the 0x7FF boundary, and reads each burst back against a model array. Directed transfers cover foreign type codes, transfers with no stop, both WP windows and a read that ends with a master not-acknowledge.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int ADDR_W = 11,
  parameter int PAGE_BYTES = 16,
  parameter int TWR_CYCLES = 5000,
  parameter logic [3:0] TYPE_CODE = 4'b1010,
  parameter logic [7:0] POISON = 8'hE5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp,
  output logic sda_oe,
  output logic busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK_W = ADDR_W - 8;
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = PG_W + 1;
  localparam int TMR_W = $clog2(TWR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TWR_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAGE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RDATA} ph_t;

  ph_t ph;
  logic scl_q, sda_q, in_ack, rd_mode, mack, wp_win, wp_cancel, aborted;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [BLK_W-1:0] blk;
  logic [ADDR_W-1:0] ptr, base;
  logic [CNT_W-1:0] wcount, ci;
  logic [PG_W-1:0] slot;
  logic [TMR_W-1:0] tmr;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE_BYTES];

  wire scl_rise  = scl_in & ~scl_q;
  wire scl_fall  = ~scl_in & scl_q;
  wire start_det = ~busy & scl_in & scl_q & sda_q & ~sda_in;
  wire stop_det  = ~busy & scl_in & scl_q & ~sda_q & sda_in;
  wire bus_step  = ~busy & ~start_det & ~stop_det & (ph != S_IDLE);
  wire byte_end  = bus_step & scl_fall & (bitcnt == 4'd8) & ~in_ack;
  wire buf_we    = byte_end & (ph == S_WDATA);

  wire [7:0] rd_byte = mem[ptr];
  wire abort_now = busy & wp & ~aborted;
  wire mem_we = busy & ~abort_now & (ci < wcount);
  wire [ADDR_W-1:0] mem_wa = base + ADDR_W'(ci);
  wire [7:0] mem_wd = aborted ? POISON : pbuf[ci[PG_W-1:0]];
  wire done = busy & ~abort_now & (tmr == TMR_LAST) & (ci >= wcount);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[mem_wa] <= mem_wd;
    end

  always_ff @(posedge clk)
    if (buf_we) pbuf[slot] <= shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      in_ack <= 1'b0;
      rd_mode <= 1'b0;
      mack <= 1'b0;
      wp_win <= 1'b0;
      wp_cancel <= 1'b0;
      aborted <= 1'b0;
      bitcnt <= '0;
      shreg <= '0;
      blk <= '0;
      ptr <= '0;
      base <= '0;
      wcount <= '0;
      ci <= '0;
      slot <= '0;
      tmr <= '0;
      sda_oe <= 1'b0;
      busy <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (busy) begin
        if (tmr != TMR_LAST) tmr <= tmr + 1'b1;
        if (abort_now) begin
          aborted <= 1'b1;
          ci <= '0;
        end else if (mem_we) begin
          ci <= ci + 1'b1;
        end
        if (done) begin
          busy <= 1'b0;
          ptr <= base + ADDR_W'(wcount);
        end
      end else if (start_det) begin
        ph <= S_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        ph <= S_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        if (ph == S_WDATA && wcount != '0 && !wp_cancel && !wp) begin
          busy <= 1'b1;
          tmr <= '0;
          ci <= '0;
          aborted <= 1'b0;
        end
      end else if (ph != S_IDLE) begin
        if (ph == S_WDATA && wp_win && wp) wp_cancel <= 1'b1;
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            if (ph != S_RDATA) shreg <= {shreg[6:0], sda_in};
            bitcnt <= bitcnt + 1'b1;
            if (ph == S_WDATA && bitcnt == 4'd7 && wcount == '0) begin
              wp_win <= 1'b1;
              if (wp) wp_cancel <= 1'b1;
            end
          end else if (ph == S_RDATA) begin
            mack <= ~sda_in;
          end
        end else if (scl_fall) begin
          if (bitcnt < 4'd8) begin
            if (ph == S_RDATA) sda_oe <= ~shreg[3'd7 - bitcnt[2:0]];
          end else if (!in_ack) begin
            in_ack <= 1'b1;
            case (ph)
              S_DEV:
                if (shreg[7:4] == TYPE_CODE) begin
                  sda_oe <= 1'b1;
                  blk <= shreg[BLK_W:1];
                  rd_mode <= shreg[0];
                  if (shreg[0]) ptr[ADDR_W-1:8] <= shreg[BLK_W:1];
                end else begin
                  ph <= S_IDLE;
                  in_ack <= 1'b0;
                end
              S_WADDR: begin
                sda_oe <= 1'b1;
                ptr <= {blk, shreg};
                base <= {blk, shreg};
                wcount <= '0;
                slot <= '0;
                wp_win <= 1'b0;
                wp_cancel <= 1'b0;
              end
              S_WDATA: begin
                sda_oe <= 1'b1;
                slot <= slot + 1'b1;
                if (wcount != CNT_FULL) wcount <= wcount + 1'b1;
              end
              S_RDATA: begin
                sda_oe <= 1'b0;
                mack <= 1'b0;
              end
              default: ;
            endcase
          end else begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            case (ph)
              S_DEV:
                if (rd_mode) begin
                  ph <= S_RDATA;
                  shreg <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  ptr <= ptr + 1'b1;
                end else begin
                  ph <= S_WADDR;
                  sda_oe <= 1'b0;
                end
              S_WADDR: begin
                ph <= S_WDATA;
                sda_oe <= 1'b0;
              end
              S_RDATA:
                if (mack) begin
                  shreg <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  ptr <= ptr + 1'b1;
                end else begin
                  ph <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              default: sda_oe <= 1'b0;
            endcase
          end
        end
      end
    end
  end

  assert_quiet_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  assert_drive_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(scl_q) && !$past(scl_in)));

  assert_foreign_code_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && ph == S_DEV && shreg[7:4] != TYPE_CODE) |=> (!sda_oe && ph == S_IDLE));

  assert_cancel_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && wp_cancel) |=> !busy);

  assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));
endmodule

// File: tb/sim_twowire_eeprom.sv
module sim_twowire_eeprom;
  localparam int TWR = 400;
  localparam int PAGE = 4;
  localparam logic [7:0] POISON = 8'hE5;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, busy;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, busy_clks = 0, r11_viol = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  logic [7:0] model [2048];
  logic [7:0] wbuf [PAGE];
  logic [7:0] rbuf [8];

  always #10 clk = ~clk;

  twowire_eeprom #(.PAGE_BYTES(PAGE), .TWR_CYCLES(TWR), .POISON(POISON)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .wp(wp),
    .sda_oe(sda_oe), .busy(busy));

  always @(negedge clk) begin
    if (busy) busy_clks <= busy_clks + 1;
    if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) r11_viol <= r11_viol + 1;
    scl_prev <= scl_m;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] dev_byte(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  function automatic logic [7:0] expect_at(input logic [10:0] a, input int i);
    return model[11'(a + 11'(i))];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(4); sda_m = 1'b0; tick(4); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(2); scl_m = 1'b1; tick(4); sda_m = 1'b1; tick(4);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(2); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(2); ack = ~sda_line; tick(2); scl_m = 1'b0; tick(2);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2); scl_m = 1'b1; tick(2); b[i] = sda_line; tick(2); scl_m = 1'b0;
    end
    tick(1); sda_m = ~give_ack; tick(1); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(2); sda_m = 1'b1;
  endtask

  task automatic write_bytes(input logic [10:0] a, input int n, input logic do_stop, output logic allack);
    logic k;
    allack = 1'b1;
    bus_start();
    put_byte(dev_byte(a, 1'b0), k); allack &= k;
    put_byte(a[7:0], k); allack &= k;
    for (int i = 0; i < n; i++) begin put_byte(wbuf[i], k); allack &= k; end
    if (do_stop) bus_stop();
  endtask

  task automatic read_bytes(input logic [10:0] a, input int n);
    logic k;
    bus_start();
    put_byte(dev_byte(a, 1'b0), k);
    put_byte(a[7:0], k);
    bus_start();
    put_byte(dev_byte(a, 1'b1), k);
    for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic wait_idle();
    tick(2);
    for (int k = 0; k < 4 * TWR && busy; k++) tick(1);
  endtask

  task automatic commit_model(input logic [10:0] a, input int n);
    for (int i = 0; i < n; i++) model[11'(a + 11'(i))] = wbuf[i];
  endtask

  task automatic verify(input string tag, input logic [10:0] a, input int n);
    read_bytes(a, n);
    for (int i = 0; i < n; i++) chk(tag, rbuf[i], expect_at(a, i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok, k;
    int unused_seed;
    unused_seed = $urandom(32'd2718);
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    tick(3);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1; tick(3);
    verify("R1 blank array", 11'h123, 2);
    verify("R1 blank array", 11'h7A0, 3);

    scl_m = 1'b0; tick(2);
    put_byte(8'hA0, k);
    chk("R2 no ack before start", k, 0);
    put_byte(8'h00, k);
    chk("R2 no ack before start", k, 0);
    sda_m = 1'b1; scl_m = 1'b1; tick(4);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    busy_clks = 0;
    write_bytes(11'h105, 3, 1'b1, ok);
    chk("R4 all bytes acked", ok, 1);
    wait_idle();
    chk("R8 busy length", busy_clks, TWR);
    commit_model(11'h105, 3);
    verify("R4 readback", 11'h105, 3);

    bus_start();
    put_byte(8'hB0, k);
    chk("R3 foreign code nack", k, 0);
    put_byte(8'hA0, k);
    chk("R3 idle after foreign code", k, 0);
    bus_stop();

    wbuf[0] = 8'h5C; wbuf[1] = 8'h6D;
    write_bytes(11'h200, 2, 1'b0, ok);
    read_bytes(11'h200, 2);
    chk("R5 no commit without stop", busy, 0);
    chk("R5 data discarded", rbuf[0], 8'hFF);
    chk("R5 data discarded", rbuf[1], 8'hFF);

    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    bus_start();
    put_byte(dev_byte(11'h240, 1'b0), k);
    put_byte(8'h40, k);
    put_byte(wbuf[0], k);
    wp = 1'b1; tick(4); wp = 1'b0;
    put_byte(wbuf[1], k);
    bus_stop(); tick(4);
    chk("R6 cancel keeps busy low", busy, 0);
    verify("R6 cancelled write", 11'h240, 2);
    wp = 1'b1;
    write_bytes(11'h250, 2, 1'b1, ok);
    tick(4);
    chk("R6 held wp blocks", busy, 0);
    wp = 1'b0;
    verify("R6 held wp blocks", 11'h250, 2);

    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    write_bytes(11'h300, 2, 1'b1, ok);
    tick(20); wp = 1'b1; tick(10); wp = 1'b0;
    wait_idle();
    model[11'h300] = POISON; model[11'h301] = POISON;
    verify("R7 poisoned after abort", 11'h300, 2);

    wbuf[0] = 8'h77;
    busy_clks = 0;
    write_bytes(11'h410, 1, 1'b1, ok);
    chk("R8 busy raised", busy, 1);
    bus_start();
    put_byte(8'hA0, k);
    chk("R8 no ack while busy", k, 0);
    bus_stop();
    wait_idle();
    chk("R8 busy length with traffic", busy_clks, TWR);
    commit_model(11'h410, 1);
    verify("R8 write completed", 11'h410, 1);

    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
    write_bytes(11'h7FE, 3, 1'b1, ok);
    wait_idle();
    commit_model(11'h7FE, 3);
    chk("R10 write wrap to 000", model[0], 8'h7C);
    verify("R10 read wrap", 11'h7FF, 2);

    bus_start();
    put_byte(dev_byte(11'h105, 1'b0), k);
    put_byte(8'h05, k);
    bus_start();
    put_byte(dev_byte(11'h105, 1'b1), k);
    get_byte(1'b1, rbuf[0]);
    get_byte(1'b0, rbuf[1]);
    chk("R9 sequential byte 0", rbuf[0], 8'h11);
    chk("R9 sequential byte 1", rbuf[1], 8'h22);
    chk("R9 released after nack", sda_oe, 0);
    put_byte(8'hA0, k);
    chk("R9 idle after nack", k, 0);
    bus_stop();

    for (int it = 0; it < 25; it++) begin
      logic [10:0] a;
      int n;
      a = 11'($urandom);
      n = 1 + int'($urandom % PAGE);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_bytes(a, n, 1'b1, ok);
      chk("R4 random acks", ok, 1);
      wait_idle();
      commit_model(a, n);
      verify("R4 random readback", a, n);
    end
    for (int it = 0; it < 10; it++) verify("R9 random sequential read", 11'($urandom), 4);

    chk("R11 sda_oe steady while scl high", r11_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule